// File: doc/BRIEF.md
# Launch-Capture Delay Test Sequencer

This block drives one path-delay measurement through a scan chain whose cells can be switched into a flush-delay line. It first shifts a serial vector into the chain with the two non-overlapping scan clocks. It then raises both scan clocks together, so the chain becomes a transparent delay line. Next it holds the gated system clock high for a programmed number of ticks. The transition launched into the path under test travels down the line while that clock is high. When the clock falls, the edge position is frozen. The block then drops both scan clocks and shifts the frozen snapshot out, one bit at a time.

The serial input vector arrives on a valid/ready stream. The block raises `sin_ready_o` only while it waits for the next load bit. It holds that bit until the A and B scan pulses for it have finished, so a slow source stalls the load without losing data.

The snapshot leaves on a second valid/ready stream. Each bit stays valid and stable until the sink accepts it, so a sink that withholds ready pauses the unload without corrupting it. The interval and both scan lengths are sampled once, when a start pulse is accepted. A zero interval is refused with an error flag.

Top module: `lc_delay_seq`

## Requirements
- R1: After reset, the block is idle: `busy_o`, `done_o`, `err_o`, `sin_ready_o`, `snap_valid_o`, `scan_a_o`, `scan_b_o` and `sys_clk_o` are all 0.
- R2: For each load bit, the block accepts the bit on the cycle where `sin_valid_i` and `sin_ready_o` are both high. It then gives one cycle of `scan_a_o` alone, followed by one cycle of `scan_b_o` alone, with `scan_si_o` holding the accepted bit during both. The total number of cycles with B alone equals the load length plus the unload length minus one (or the load length alone when the unload length is 0).
- R3: After the load, both scan clocks are high for one cycle with `sys_clk_o` low. Then `sys_clk_o` is high for exactly the programmed interval in cycles, with both scan clocks high throughout.
- R4: After `sys_clk_o` falls, both scan clocks stay high for exactly one more cycle, then fall together. Over one run there are exactly two cycles with both scan clocks high and `sys_clk_o` low.
- R5: The unload presents `scan_so_i` on `snap_data_o` with `snap_valid_o` high. The bit is held stable until `snap_ready_i` is high. Between accepted bits the chain is shifted by one A-only pulse and then one B-only pulse. The cell at the far end of the chain comes out first. Exactly the unload length of bits is delivered.
- R6: A start in idle with an interval of 0 sets `err_o`. In that case `busy_o` stays low and no scan or system clock pulses are issued. `err_o` is cleared by the next accepted start.
- R7: `busy_o` rises in the cycle after an accepted start and falls in the cycle after the last snapshot bit is accepted. In that same cycle `done_o` is high for exactly one cycle.
- R8: A start pulse that arrives while `busy_o` is high is ignored: the running measurement keeps its sampled interval and lengths, and `err_o` is not set.
- R9: A load length of 0 skips the load phase. An unload length of 0 ends the run, with the done pulse, in the cycle after both scan clocks fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer tick clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| interval_i | input | INT_W | Launch-capture interval in ticks |
| load_len_i | input | LEN_W | Number of bits to scan in |
| unload_len_i | input | LEN_W | Number of snapshot bits to scan out |
| sin_data_i | input | 1 | Load stream data bit |
| sin_valid_i | input | 1 | Load stream valid |
| sin_ready_o | output | 1 | Load stream ready |
| scan_so_i | input | 1 | Serial output of the far end of the chain |
| scan_si_o | output | 1 | Serial input to the chain |
| scan_a_o | output | 1 | Scan clock A |
| scan_b_o | output | 1 | Scan clock B |
| sys_clk_o | output | 1 | Gated system clock (launch window) |
| snap_data_o | output | 1 | Snapshot stream data bit |
| snap_valid_o | output | 1 | Snapshot stream valid |
| snap_ready_i | input | 1 | Snapshot stream ready |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Last start refused (zero interval) |

## Verification
Every output is decoded from the state register, so each response appears one cycle after the clock edge that caused it. Each stream handshake is taken on the edge where valid and ready are both high, and the matching clock pulses follow in the next two cycles. The busy flag rises one cycle after the start edge. The done pulse and the fall of busy come one cycle after the last snapshot handshake.

The bench applies stimulus and samples outputs on the falling edge, so every check reads the value settled after the preceding rising edge. An environment model of the chain shifts on each rising edge from the clock pins, and its contents are compared with a snapshot computed from the requirements. Pulse counts are taken over the whole run and compared once the done pulse is seen, so the checks do not depend on how long the random stream stalls last.

// File: rtl/lc_seq_pkg.sv
package lc_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LD_WAIT,
    ST_LD_A,
    ST_LD_B,
    ST_FLUSH,
    ST_LAUNCH,
    ST_HOLD,
    ST_RELEASE,
    ST_SNAP,
    ST_UL_A,
    ST_UL_B
  } seq_state_t;
endpackage

// File: rtl/lc_down_counter.sv
module lc_down_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         is_one_o
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - ONE;
  end

  assign is_one_o = (cnt_q == ONE);
endmodule

// File: rtl/lc_seq_fsm.sv
module lc_seq_fsm
  import lc_seq_pkg::*;
#(
  parameter int INT_W = 10,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [INT_W-1:0] interval_i,
  input  logic [LEN_W-1:0] load_len_i,
  input  logic [LEN_W-1:0] unload_len_i,
  input  logic             sin_valid_i,
  input  logic             sin_data_i,
  input  logic             snap_ready_i,
  input  logic             bit_one_i,
  input  logic             tick_one_i,
  output seq_state_t       state_o,
  output logic             bit_load_o,
  output logic [LEN_W-1:0] bit_val_o,
  output logic             bit_dec_o,
  output logic             tick_load_o,
  output logic [INT_W-1:0] tick_val_o,
  output logic             tick_dec_o,
  output logic             si_o,
  output logic             done_o,
  output logic             err_o
);
  seq_state_t       state_q, state_d;
  logic [INT_W-1:0] int_q;
  logic [LEN_W-1:0] unl_q;
  logic             si_q, done_q, err_q;
  logic             accept, reject;

  assign accept = (state_q == ST_IDLE) && start_i && (interval_i != '0);
  assign reject = (state_q == ST_IDLE) && start_i && (interval_i == '0);

  always_comb begin
    state_d     = state_q;
    bit_load_o  = 1'b0;
    bit_val_o   = load_len_i;
    bit_dec_o   = 1'b0;
    tick_load_o = 1'b0;
    tick_val_o  = int_q;
    tick_dec_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          bit_load_o = 1'b1;
          state_d    = (load_len_i != '0) ? ST_LD_WAIT : ST_FLUSH;
        end
      end
      ST_LD_WAIT: if (sin_valid_i) state_d = ST_LD_A;
      ST_LD_A:    state_d = ST_LD_B;
      ST_LD_B: begin
        if (bit_one_i) state_d = ST_FLUSH;
        else begin
          bit_dec_o = 1'b1;
          state_d   = ST_LD_WAIT;
        end
      end
      ST_FLUSH: begin
        tick_load_o = 1'b1;
        state_d     = ST_LAUNCH;
      end
      ST_LAUNCH: begin
        if (tick_one_i) state_d = ST_HOLD;
        else tick_dec_o = 1'b1;
      end
      ST_HOLD: state_d = ST_RELEASE;
      ST_RELEASE: begin
        if (unl_q == '0) state_d = ST_IDLE;
        else begin
          bit_load_o = 1'b1;
          bit_val_o  = unl_q;
          state_d    = ST_SNAP;
        end
      end
      ST_SNAP: begin
        if (snap_ready_i) begin
          if (bit_one_i) state_d = ST_IDLE;
          else begin
            bit_dec_o = 1'b1;
            state_d   = ST_UL_A;
          end
        end
      end
      ST_UL_A: state_d = ST_UL_B;
      ST_UL_B: state_d = ST_SNAP;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      int_q   <= '0;
      unl_q   <= '0;
      si_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q != ST_IDLE) && (state_d == ST_IDLE);
      if (accept) begin
        int_q <= interval_i;
        unl_q <= unload_len_i;
        err_q <= 1'b0;
      end else if (reject) begin
        err_q <= 1'b1;
      end
      if (state_q == ST_LD_WAIT && sin_valid_i) si_q <= sin_data_i;
    end
  end

  assign state_o = state_q;
  assign si_o    = si_q;
  assign done_o  = done_q;
  assign err_o   = err_q;
endmodule

// File: rtl/lc_seq_decode.sv
module lc_seq_decode
  import lc_seq_pkg::*;
(
  input  seq_state_t state_i,
  input  logic       scan_so_i,
  output logic       scan_a_o,
  output logic       scan_b_o,
  output logic       sys_clk_o,
  output logic       sin_ready_o,
  output logic       snap_valid_o,
  output logic       snap_data_o,
  output logic       busy_o
);
  logic flush_win;

  assign flush_win    = (state_i == ST_FLUSH) || (state_i == ST_LAUNCH) ||
                        (state_i == ST_HOLD);
  assign scan_a_o     = flush_win || (state_i == ST_LD_A) || (state_i == ST_UL_A);
  assign scan_b_o     = flush_win || (state_i == ST_LD_B) || (state_i == ST_UL_B);
  assign sys_clk_o    = (state_i == ST_LAUNCH);
  assign sin_ready_o  = (state_i == ST_LD_WAIT);
  assign snap_valid_o = (state_i == ST_SNAP);
  assign snap_data_o  = (state_i == ST_SNAP) && scan_so_i;
  assign busy_o       = (state_i != ST_IDLE);
endmodule

// File: rtl/lc_delay_seq.sv
module lc_delay_seq
  import lc_seq_pkg::*;
#(
  parameter int INT_W = 10,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [INT_W-1:0] interval_i,
  input  logic [LEN_W-1:0] load_len_i,
  input  logic [LEN_W-1:0] unload_len_i,
  input  logic             sin_data_i,
  input  logic             sin_valid_i,
  output logic             sin_ready_o,
  input  logic             scan_so_i,
  output logic             scan_si_o,
  output logic             scan_a_o,
  output logic             scan_b_o,
  output logic             sys_clk_o,
  output logic             snap_data_o,
  output logic             snap_valid_o,
  input  logic             snap_ready_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  seq_state_t       state;
  logic             bit_load, bit_dec, bit_one;
  logic [LEN_W-1:0] bit_val;
  logic             tick_load, tick_dec, tick_one;
  logic [INT_W-1:0] tick_val;

  lc_seq_fsm #(.INT_W(INT_W), .LEN_W(LEN_W)) fsm_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .interval_i(interval_i),
    .load_len_i(load_len_i), .unload_len_i(unload_len_i),
    .sin_valid_i(sin_valid_i), .sin_data_i(sin_data_i),
    .snap_ready_i(snap_ready_i), .bit_one_i(bit_one), .tick_one_i(tick_one),
    .state_o(state), .bit_load_o(bit_load), .bit_val_o(bit_val),
    .bit_dec_o(bit_dec), .tick_load_o(tick_load), .tick_val_o(tick_val),
    .tick_dec_o(tick_dec), .si_o(scan_si_o), .done_o(done_o), .err_o(err_o)
  );

  lc_down_counter #(.W(LEN_W)) bit_cnt_i (
    .clk(clk), .rst_n(rst_n), .load_i(bit_load), .load_val_i(bit_val),
    .dec_i(bit_dec), .is_one_o(bit_one)
  );

  lc_down_counter #(.W(INT_W)) tick_cnt_i (
    .clk(clk), .rst_n(rst_n), .load_i(tick_load), .load_val_i(tick_val),
    .dec_i(tick_dec), .is_one_o(tick_one)
  );

  lc_seq_decode dec_i (
    .state_i(state), .scan_so_i(scan_so_i), .scan_a_o(scan_a_o),
    .scan_b_o(scan_b_o), .sys_clk_o(sys_clk_o), .sin_ready_o(sin_ready_o),
    .snap_valid_o(snap_valid_o), .snap_data_o(snap_data_o), .busy_o(busy_o)
  );
endmodule

// File: rtl/lc_delay_seq_chk.sv
module lc_delay_seq_chk #(
  parameter int INT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [INT_W-1:0] interval_i,
  input logic             sin_ready_o,
  input logic             scan_a_o,
  input logic             scan_b_o,
  input logic             sys_clk_o,
  input logic             snap_data_o,
  input logic             snap_valid_o,
  input logic             snap_ready_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!scan_a_o && !scan_b_o && !sys_clk_o && !snap_valid_o && !sin_ready_o));

  assert_no_clk_while_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sin_ready_o |-> (!scan_a_o && !scan_b_o));

  assert_launch_in_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sys_clk_o |-> (scan_a_o && scan_b_o));

  assert_hold_after_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_clk_o) |-> (scan_a_o && scan_b_o));

  assert_snap_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_valid_o && !snap_ready_i) |=> (snap_valid_o && $stable(snap_data_o)));

  assert_zero_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && interval_i == '0) |=> (!busy_o && err_o));

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_busy_no_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> !busy_o);
endmodule

bind lc_delay_seq lc_delay_seq_chk #(.INT_W(INT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .interval_i(interval_i),
  .sin_ready_o(sin_ready_o), .scan_a_o(scan_a_o), .scan_b_o(scan_b_o),
  .sys_clk_o(sys_clk_o), .snap_data_o(snap_data_o), .snap_valid_o(snap_valid_o),
  .snap_ready_i(snap_ready_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/lc_delay_seq_tb_top.sv
module lc_delay_seq_tb_top;
  localparam int CH    = 16;
  localparam int INT_W = 10;
  localparam int LEN_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [INT_W-1:0] interval_i = '0;
  logic [LEN_W-1:0] load_len_i = '0, unload_len_i = '0;
  logic             sin_data_i = 1'b0, sin_valid_i = 1'b0, snap_ready_i = 1'b0;
  logic             sin_ready_o, scan_so_i, scan_si_o, scan_a_o, scan_b_o, sys_clk_o;
  logic             snap_data_o, snap_valid_o, busy_o, done_o, err_o;

  always #5ns clk = ~clk;

  lc_delay_seq #(.INT_W(INT_W), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .interval_i(interval_i),
    .load_len_i(load_len_i), .unload_len_i(unload_len_i),
    .sin_data_i(sin_data_i), .sin_valid_i(sin_valid_i), .sin_ready_o(sin_ready_o),
    .scan_so_i(scan_so_i), .scan_si_o(scan_si_o), .scan_a_o(scan_a_o),
    .scan_b_o(scan_b_o), .sys_clk_o(sys_clk_o), .snap_data_o(snap_data_o),
    .snap_valid_o(snap_valid_o), .snap_ready_i(snap_ready_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  // environment: chain model, stream drivers, pulse counters
  logic [CH-1:0] chain, dvec, rx;
  logic          clr = 1'b0, put_val = 1'b0;
  int            cur_m = 0, sin_idx, rx_n, sys_cnt, bonly_cnt, ab_nosys_cnt;
  int            n_checks = 0, n_fails = 0;

  assign scan_so_i = chain[CH-1];

  always @(posedge clk) begin
    if (clr) begin
      chain <= '0; rx <= '0; sin_idx <= 0; rx_n <= 0;
      sys_cnt <= 0; bonly_cnt <= 0; ab_nosys_cnt <= 0;
    end else begin
      if (scan_b_o && !scan_a_o) begin
        chain <= {chain[CH-2:0], scan_si_o};
        bonly_cnt <= bonly_cnt + 1;
      end else if (scan_a_o && scan_b_o && sys_clk_o) begin
        chain <= {chain[CH-2:0], put_val};
      end
      if (sys_clk_o) sys_cnt <= sys_cnt + 1;
      if (scan_a_o && scan_b_o && !sys_clk_o) ab_nosys_cnt <= ab_nosys_cnt + 1;
      if (sin_valid_i && sin_ready_o) sin_idx <= sin_idx + 1;
      if (snap_valid_o && snap_ready_i) begin
        if (rx_n < CH) rx[rx_n] <= snap_data_o;
        rx_n <= rx_n + 1;
      end
    end
  end

  always @(negedge clk) begin
    sin_valid_i  <= (sin_idx < cur_m) && ($urandom % 4 != 0);
    sin_data_i   <= (sin_idx < CH) ? dvec[sin_idx] : 1'b0;
    snap_ready_i <= ($urandom % 3 != 0);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [CH-1:0] expect_chain(input int m, input int n,
                                                 input logic [CH-1:0] d, input logic p);
    logic [CH-1:0] e = '0;
    for (int i = 0; i < m; i++) e = {e[CH-2:0], d[i]};
    for (int i = 0; i < n; i++) e = {e[CH-2:0], p};
    return e;
  endfunction

  task automatic run_case(input int m, input int u, input int n, input bit poke);
    logic [CH-1:0] e;
    int            wait_c;
    @(negedge clk);
    clr = 1'b1; dvec = CH'($urandom); put_val = 1'($urandom); cur_m = m;
    @(negedge clk);
    clr = 1'b0;
    start_i = 1'b1; interval_i = INT_W'(n);
    load_len_i = LEN_W'(m); unload_len_i = LEN_W'(u);
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R7 busy after start", int'(busy_o), 1);
    check(err_o == 1'b0, "R6 err cleared by accepted start", int'(err_o), 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      start_i = 1'b1; interval_i = '0; load_len_i = 8'd3; unload_len_i = 8'd1;
      @(negedge clk);
      start_i = 1'b0;
      check(err_o == 1'b0, "R8 start while busy sets no err", int'(err_o), 0);
    end
    wait_c = 0;
    while (!done_o && wait_c < 5000) begin
      @(negedge clk);
      wait_c++;
    end
    check(done_o == 1'b1, "R7 done pulse seen", int'(done_o), 1);
    check(busy_o == 1'b0, "R7 busy low with done", int'(busy_o), 0);
    e = expect_chain(m, n, dvec, put_val);
    check(sys_cnt == n, "R3 launch width", sys_cnt, n);
    check(ab_nosys_cnt == 2, "R4 flush cycles without launch", ab_nosys_cnt, 2);
    check(bonly_cnt == m + ((u > 0) ? u - 1 : 0), "R2 B-only shift pulses",
          bonly_cnt, m + ((u > 0) ? u - 1 : 0));
    check(rx_n == u, "R5 snapshot bit count", rx_n, u);
    for (int k = 0; k < u; k++)
      check(rx[k] == e[CH-1-k], "R5 snapshot bit value", int'(rx[k]), int'(e[CH-1-k]));
    @(negedge clk);
    check(done_o == 1'b0, "R7 done one cycle", int'(done_o), 0);
  endtask

  task automatic zero_interval_case();
    int b0, s0;
    @(negedge clk);
    b0 = bonly_cnt; s0 = sys_cnt;
    start_i = 1'b1; interval_i = '0; load_len_i = 8'd4; unload_len_i = 8'd4;
    @(negedge clk);
    start_i = 1'b0;
    check(err_o == 1'b1, "R6 err on zero interval", int'(err_o), 1);
    check(busy_o == 1'b0, "R6 busy stays low", int'(busy_o), 0);
    repeat (6) @(negedge clk);
    check(bonly_cnt == b0 && sys_cnt == s0, "R6 no clock pulses",
          bonly_cnt - b0 + sys_cnt - s0, 0);
    check(sin_ready_o == 1'b0 && busy_o == 1'b0, "R6 still idle", int'(busy_o), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd2024);
    clr = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check(busy_o == 0 && done_o == 0 && err_o == 0, "R1 idle flags", int'(busy_o), 0);
    check(!scan_a_o && !scan_b_o && !sys_clk_o, "R1 clocks low", int'(scan_a_o), 0);
    check(!sin_ready_o && !snap_valid_o, "R1 streams idle", int'(snap_valid_o), 0);
    // directed corners
    run_case(16, 16, 5, 1'b0);
    run_case(8, 12, 1, 1'b0);     // shortest launch window
    run_case(0, 10, 4, 1'b0);     // R9 load skipped
    run_case(6, 0, 3, 1'b0);      // R9 unload skipped
    zero_interval_case();         // R6
    run_case(10, 16, 7, 1'b1);    // R8 start while busy, clears R6 err
    run_case(4, 16, 300, 1'b0);   // long window saturates the line
    // constrained random
    for (int t = 0; t < 25; t++)
      run_case(int'($urandom % 17), int'($urandom % 17), 1 + int'($urandom % 20),
               1'($urandom % 2));
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule